// File: doc/BRIEF.md
# Parallel Quarter-Rate Quadrature Mixer

This block shifts a real-valued sample stream down to complex baseband when the local oscillator runs at exactly one quarter of the sample rate. Samples arrive four per clock on parallel lanes. Lane 0 carries the oldest sample of each group and lane 3 the newest. One oscillator period therefore covers exactly one clock's worth of lanes, so each lane always sees the same oscillator phase.

At that frequency the oscillator only takes the values +1, 0 and -1, so no multiplier or sine table is needed. The cosine branch over phases 0..3 is +1, 0, -1, 0. The sine branch is 0, +1, 0, -1. Every lane is either passed through, negated, or known to be zero.

The block produces two four-lane output sets, in-phase and quadrature. Each output sample is one bit wider than the input, so negation cannot overflow. Positions known to be zero are driven as constant zero and have no register behind them. A single register stage aligns the data with a valid flag. Filtering and decimation belong to the stages that follow.

Top module: `quarter_rate_mixer`

## Requirements
- R1: While reset is asserted and after its release, before any valid input, `out_valid` is 0 and every lane of `out_i` and `out_q` is zero.
- R2: `out_valid` equals `in_valid` from the previous clock cycle.
- R3: One cycle after a valid input, in-phase lane 0 equals input lane 0, sign-extended to SAMPLE_W+1 bits.
- R4: One cycle after a valid input, in-phase lane 2 equals the two's-complement negation of input lane 2 in SAMPLE_W+1 bits. The most negative input, -2^(SAMPLE_W-1), gives +2^(SAMPLE_W-1).
- R5: One cycle after a valid input, quadrature lane 1 equals input lane 1, sign-extended.
- R6: One cycle after a valid input, quadrature lane 3 equals the negation of input lane 3 in SAMPLE_W+1 bits.
- R7: In-phase lanes 1 and 3 and quadrature lanes 0 and 2 are always zero.
- R8: A cycle with `in_valid` low leaves every output lane unchanged.
- R9: Input lane k sits in `in_samples[k*SAMPLE_W +: SAMPLE_W]`. Output lane k sits in `out_i` and `out_q` at `[k*(SAMPLE_W+1) +: SAMPLE_W+1]`. All values are two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group is valid |
| in_samples | input | 4*SAMPLE_W | Four real samples, lane 0 oldest |
| out_valid | output | 1 | Output group is valid |
| out_i | output | 4*(SAMPLE_W+1) | In-phase lanes |
| out_q | output | 4*(SAMPLE_W+1) | Quadrature lanes |

## Verification
A wrong internal state here would show up as a sign error or a swapped lane on the very next valid cycle. The pass-through lanes and the negated lanes disagree for any nonzero sample, so one random group exposes the fault. A stuck or free-running load shows up in the first cycle after an invalid input. A non-zero known-zero lane shows up at once. The most negative input is driven on its own because a narrow negation only fails on that value.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        COEF_ZERO = 2'd0,
        COEF_POS  = 2'd1,
        COEF_NEG  = 2'd2
    } coef_t;

    function automatic coef_t cos_coef(input int phase);
        unique case (phase % 4)
            0:       return COEF_POS;
            2:       return COEF_NEG;
            default: return COEF_ZERO;
        endcase
    endfunction

    function automatic coef_t sin_coef(input int phase);
        unique case (phase % 4)
            1:       return COEF_POS;
            3:       return COEF_NEG;
            default: return COEF_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/qmix_lane.sv
module qmix_lane
    import qmix_pkg::*;
#(
    parameter int    SAMPLE_W = 12,
    parameter coef_t COEF     = COEF_POS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] din,
    output logic [SAMPLE_W:0]   dout
);

    localparam int OUT_W = SAMPLE_W + 1;

    logic [OUT_W-1:0] ext;
    logic [OUT_W-1:0] nxt;

    always_comb begin
        ext = {din[SAMPLE_W-1], din};
        if (COEF == COEF_NEG) begin
            nxt = ~ext + OUT_W'(1);
        end else begin
            nxt = ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= nxt;
        end
    end

    generate
        if (COEF == COEF_NEG) begin : g_chk_neg
            // R4 / R6: negated lane, widened so no overflow
            assert_negate_R4: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> ($signed(dout) == -$signed($past(din))));
        end else begin : g_chk_pos
            // R3 / R5: pass-through lane
            assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> ($signed(dout) == $signed($past(din))));
        end
    endgenerate

    // R8: invalid cycles leave the lane alone
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));

endmodule

// File: rtl/qmix_valid_stage.sv
module qmix_valid_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vout <= 1'b0;
        end else begin
            vout <= vin;
        end
    end

    // R2: flag delayed by exactly one cycle
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vin |=> vout);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vin |=> !vout);

endmodule

// File: rtl/quarter_rate_mixer.sv
module quarter_rate_mixer
    import qmix_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [LANES*SAMPLE_W-1:0]      in_samples,
    output logic                           out_valid,
    output logic [LANES*(SAMPLE_W+1)-1:0]  out_i,
    output logic [LANES*(SAMPLE_W+1)-1:0]  out_q
);

    localparam int OUT_W = SAMPLE_W + 1;

    qmix_valid_stage u_valid (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .vout  (out_valid)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            localparam coef_t CI = cos_coef(k);
            localparam coef_t CQ = sin_coef(k);

            if (CI != COEF_ZERO) begin : g_i
                qmix_lane #(.SAMPLE_W(SAMPLE_W), .COEF(CI)) u_i (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .load  (in_valid),
                    .din   (in_samples[k*SAMPLE_W +: SAMPLE_W]),
                    .dout  (out_i[k*OUT_W +: OUT_W])
                );
            end else begin : g_i0
                // R7: known-zero in-phase position
                assign out_i[k*OUT_W +: OUT_W] = '0;
            end

            if (CQ != COEF_ZERO) begin : g_q
                qmix_lane #(.SAMPLE_W(SAMPLE_W), .COEF(CQ)) u_q (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .load  (in_valid),
                    .din   (in_samples[k*SAMPLE_W +: SAMPLE_W]),
                    .dout  (out_q[k*OUT_W +: OUT_W])
                );
            end else begin : g_q0
                // R7: known-zero quadrature position
                assign out_q[k*OUT_W +: OUT_W] = '0;
            end
        end
    endgenerate

endmodule

// File: tb/quarter_rate_mixer_test.sv
module quarter_rate_mixer_test;

    localparam int W = 12;
    localparam int O = W + 1;
    localparam int L = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [L*W-1:0]   in_samples = '0;
    logic             out_valid;
    logic [L*O-1:0]   out_i;
    logic [L*O-1:0]   out_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [L*O-1:0] exp_i = '0;
    logic [L*O-1:0] exp_q = '0;
    logic           exp_v = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    quarter_rate_mixer #(.SAMPLE_W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .out_valid  (out_valid),
        .out_i      (out_i),
        .out_q      (out_q)
    );

    function automatic logic [O-1:0] sx(input logic [W-1:0] v);
        return {v[W-1], v};
    endfunction

    // expected in-phase lane: +x0, -x2, zero elsewhere (R3, R4, R7)
    function automatic logic [O-1:0] ref_i(input int k, input logic [W-1:0] v);
        if (k == 0) return sx(v);
        if (k == 2) return O'(-sx(v));
        return '0;
    endfunction

    // expected quadrature lane: +x1, -x3, zero elsewhere (R5, R6, R7)
    function automatic logic [O-1:0] ref_q(input int k, input logic [W-1:0] v);
        if (k == 1) return sx(v);
        if (k == 3) return O'(-sx(v));
        return '0;
    endfunction

    function automatic string tag_i(input int k);
        if (k == 0) return "R3";
        if (k == 2) return "R4";
        return "R7";
    endfunction

    function automatic string tag_q(input int k);
        if (k == 1) return "R5";
        if (k == 3) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [O-1:0] act, input logic [O-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string extra);
        chk({"R2", extra}, O'(out_valid), O'(exp_v));
        for (int k = 0; k < L; k++) begin
            chk({tag_i(k), extra, " I"}, out_i[k*O +: O], exp_i[k*O +: O]);
            chk({tag_q(k), extra, " Q"}, out_q[k*O +: O], exp_q[k*O +: O]);
        end
    endtask

    // drive at negedge, check at the following negedge
    task automatic apply(input logic v, input logic [L*W-1:0] s);
        string extra;
        in_valid   = v;
        in_samples = s;
        extra = v ? "" : "/R8";
        exp_v = v;
        if (v) begin
            for (int k = 0; k < L; k++) begin
                exp_i[k*O +: O] = ref_i(k, s[k*W +: W]);
                exp_q[k*O +: O] = ref_q(k, s[k*W +: W]);
            end
        end
        @(negedge clk);
        compare_all(extra);
    endtask

    function automatic logic [L*W-1:0] pack4(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] c, input logic [W-1:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: state during reset
        compare_all(" R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all(" R1");

        // directed corners (R9 lane order)
        apply(1'b1, pack4(12'h001, 12'h002, 12'h003, 12'h004));
        apply(1'b1, pack4(12'h800, 12'h800, 12'h800, 12'h800)); // most negative, R4/R6
        apply(1'b1, pack4(12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF));
        apply(1'b1, pack4(12'hFFF, 12'h000, 12'hFFF, 12'h000));
        apply(1'b0, pack4(12'h123, 12'h456, 12'h789, 12'hABC)); // R8 hold
        apply(1'b0, '0);
        apply(1'b1, '0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [L*W-1:0] s;
            logic           v;
            for (int k = 0; k < L; k++) begin
                int pick;
                pick = $urandom_range(0, 9);
                if (pick == 0)      s[k*W +: W] = 12'h800;
                else if (pick == 1) s[k*W +: W] = 12'h7FF;
                else                s[k*W +: W] = W'($urandom);
            end
            v = ($urandom_range(0, 3) != 0);
            apply(v, s);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule